// File: doc/BRIEF.md
# Receive Link Lock Sequencer

This block runs the lock sequence of a serial receive link. It moves the link through four states: powered down, settling on the local reference clock, searching for a transition word, and locked. From those states it derives the link status seen by the rest of the chip. It does not run on the link clocks. It runs on one system clock and is fed one-cycle ticks: one for each reference-clock period and one for each recovered parallel-clock period. It also receives a line-activity flag and a transition-word strobe, both produced by logic outside the block.

The block drives five outputs:
- a lock flag, low when the output data is valid;
- a force that drives the data outputs to zero;
- an output drive enable, low meaning the pins float;
- a clock-source select, choosing between the reference clock and the recovered clock;
- a one-cycle stretch request, raised each time that select changes, so that the clock multiplexer can widen the swapped clock phase.

The settling length and the loss-of-word timeout are parameters. The settling count defaults to 16385 reference ticks and the timeout to 2^20 recovered ticks.

Top module: `link_lock_ctrl`

## Requirements
- R1: While `sleep` is high, `drive_en` is low. One cycle after a clock edge at which `sleep` was high, the block is back in its power-down state: `lock_n`=1, `sel_recovered`=0, and the settling count restarts from zero.
- R2: While `out_en` is low, `drive_en` is low in any state. With `sleep` low and `out_en` high, `drive_en` is high.
- R3: After reset, and in the power-down, settling and search states, `lock_n`=1, `zero_data`=1 and `sel_recovered`=0.
- R4: Settling ends on the SETTLE_TICKS-th `ref_tick` counted since the state was entered. A `word_seen` strobe during settling has no effect: `lock_n` stays 1.
- R5: In the search state, a `word_seen` strobe together with `line_active` moves the block to the locked state at the next edge. There `lock_n`=0, `zero_data`=0 and `sel_recovered`=1.
- R6: In the locked state, TIMEOUT_TICKS `rec_tick` pulses with no `word_seen` return the block to the search state: `lock_n`=1, `zero_data`=1, `sel_recovered`=0.
- R7: A `word_seen` strobe in the locked state clears the timeout count to zero.
- R8: `stretch_req` is high for exactly the first cycle in which `sel_recovered` holds a new value, in either direction, and is low in all other cycles.
- R9: While locked, a low `line_active` drives `lock_n` and `zero_data` high in the same cycle. At the next edge the block moves to the search state, with the timeout count cleared.
- R10: In the search state, a `word_seen` strobe while `line_active` is low is ignored: `lock_n` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep | input | 1 | Power-down request, active high |
| out_en | input | 1 | Output enable, low floats the outputs |
| ref_tick | input | 1 | One pulse per reference-clock period |
| rec_tick | input | 1 | One pulse per recovered parallel-clock period |
| line_active | input | 1 | Serial input is toggling |
| word_seen | input | 1 | Transition word detected strobe |
| lock_n | output | 1 | Low when output data is valid |
| zero_data | output | 1 | Force the data outputs low |
| drive_en | output | 1 | Output pin drive enable |
| sel_recovered | output | 1 | 1 selects the recovered clock, 0 the reference clock |
| stretch_req | output | 1 | One-cycle request to stretch the output clock |

## Verification
The hardest case to reach is a timeout that expires exactly on the last tick while the link is otherwise healthy. Reaching it needs a full settling phase, a lock, and then a long run of recovered ticks with no transition word. The bench uses a short settling count and a short timeout. It holds `word_seen` low through a directed stretch of `rec_tick` pulses, then places a strobe one tick before expiry to exercise R7. Randomized phases then mix sleep, loss of line activity and disabled outputs on top of the locked state.

// File: rtl/lrc_pkg.sv
package lrc_pkg;
  typedef enum logic [1:0] {
    ST_OFF    = 2'd0,
    ST_SETTLE = 2'd1,
    ST_SEARCH = 2'd2,
    ST_LOCKED = 2'd3
  } lrc_state_e;
endpackage

// File: rtl/lrc_tick_counter.sv
module lrc_tick_counter #(
  parameter int unsigned LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic tick,
  output logic done
);
  localparam int unsigned W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] cnt_q, cnt_d;

  assign done = tick & ~clr & (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (clr)       cnt_d = '0;
    else if (done) cnt_d = '0;
    else if (tick) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R4 / R7: a cleared counter restarts from zero
  p_clear_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0));
endmodule

// File: rtl/lrc_fsm.sv
module lrc_fsm
  import lrc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sleep,
  input  logic       line_active,
  input  logic       word_seen,
  input  logic       settle_done,
  input  logic       tmo_done,
  output lrc_state_e state_q,
  output lrc_state_e state_d
);
  always_comb begin
    state_d = state_q;
    if (sleep) begin
      state_d = ST_OFF;
    end else begin
      unique case (state_q)
        ST_OFF:    state_d = ST_SETTLE;
        ST_SETTLE: if (settle_done) state_d = ST_SEARCH;
        ST_SEARCH: if (word_seen && line_active) state_d = ST_LOCKED;
        ST_LOCKED: if (!line_active || tmo_done) state_d = ST_SEARCH;
        default:   state_d = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_OFF;
    else        state_q <= state_d;
  end

  p_sleep_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> (state_q == ST_OFF));

  p_lock_from_search_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_LOCKED) && ($past(state_q) != ST_LOCKED) |-> ($past(state_q) == ST_SEARCH) && $past(word_seen));

  p_settle_exit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SEARCH) && ($past(state_q) == ST_SETTLE) |-> $past(settle_done));

  p_inactive_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_LOCKED) && !line_active && !sleep |=> (state_q == ST_SEARCH));

  p_timeout_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_LOCKED) && tmo_done && !sleep |=> (state_q == ST_SEARCH));
endmodule

// File: rtl/lrc_out_stage.sv
module lrc_out_stage
  import lrc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  lrc_state_e state_q,
  input  lrc_state_e state_d,
  input  logic       sleep,
  input  logic       out_en,
  input  logic       line_active,
  output logic       lock_n,
  output logic       zero_data,
  output logic       drive_en,
  output logic       sel_recovered,
  output logic       stretch_req
);
  logic valid;
  logic swap_d, stretch_q;

  assign valid         = (state_q == ST_LOCKED) & line_active;
  assign lock_n        = ~valid;
  assign zero_data     = ~valid;
  assign drive_en      = ~sleep & out_en;
  assign sel_recovered = (state_q == ST_LOCKED);
  assign swap_d        = (state_d == ST_LOCKED) ^ (state_q == ST_LOCKED);
  assign stretch_req   = stretch_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stretch_q <= 1'b0;
    else        stretch_q <= swap_d;
  end

  p_stretch_on_swap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_recovered != $past(sel_recovered)) |-> stretch_req);

  p_stretch_only_swap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stretch_req |-> (sel_recovered != $past(sel_recovered)));
endmodule

// File: rtl/link_lock_ctrl.sv
module link_lock_ctrl
  import lrc_pkg::*;
#(
  parameter int unsigned SETTLE_TICKS  = 16385,
  parameter int unsigned TIMEOUT_TICKS = 1 << 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep,
  input  logic out_en,
  input  logic ref_tick,
  input  logic rec_tick,
  input  logic line_active,
  input  logic word_seen,
  output logic lock_n,
  output logic zero_data,
  output logic drive_en,
  output logic sel_recovered,
  output logic stretch_req
);
  lrc_state_e state_q, state_d;
  logic settle_done, tmo_done;
  logic settle_clr, tmo_clr;

  assign settle_clr = (state_q != ST_SETTLE);
  assign tmo_clr    = (state_q != ST_LOCKED) | word_seen;

  lrc_tick_counter #(.LIMIT(SETTLE_TICKS)) u_settle (
    .clk(clk), .rst_n(rst_n), .clr(settle_clr), .tick(ref_tick), .done(settle_done)
  );

  lrc_tick_counter #(.LIMIT(TIMEOUT_TICKS)) u_timeout (
    .clk(clk), .rst_n(rst_n), .clr(tmo_clr), .tick(rec_tick), .done(tmo_done)
  );

  lrc_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .sleep(sleep), .line_active(line_active),
    .word_seen(word_seen), .settle_done(settle_done), .tmo_done(tmo_done),
    .state_q(state_q), .state_d(state_d)
  );

  lrc_out_stage u_out (
    .clk(clk), .rst_n(rst_n), .state_q(state_q), .state_d(state_d),
    .sleep(sleep), .out_en(out_en), .line_active(line_active),
    .lock_n(lock_n), .zero_data(zero_data), .drive_en(drive_en),
    .sel_recovered(sel_recovered), .stretch_req(stretch_req)
  );
endmodule

// File: tb/link_lock_ctrl_bench.sv
module link_lock_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int S_TICKS    = 12;
  localparam int T_TICKS    = 40;

  logic clk, rst_n;
  logic sleep, out_en, ref_tick, rec_tick, line_active, word_seen;
  logic lock_n, zero_data, drive_en, sel_recovered, stretch_req;

  int n_checks = 0;
  int n_fail   = 0;
  string tag = "R3";

  link_lock_ctrl #(.SETTLE_TICKS(S_TICKS), .TIMEOUT_TICKS(T_TICKS)) u_link_lock_ctrl (
    .clk(clk), .rst_n(rst_n), .sleep(sleep), .out_en(out_en),
    .ref_tick(ref_tick), .rec_tick(rec_tick), .line_active(line_active),
    .word_seen(word_seen), .lock_n(lock_n), .zero_data(zero_data),
    .drive_en(drive_en), .sel_recovered(sel_recovered), .stretch_req(stretch_req)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // Reference model: 0 off, 1 settle, 2 search, 3 locked
  int m_st, m_sc, m_tc, m_nx;
  logic m_str;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st <= 0; m_sc <= 0; m_tc <= 0; m_str <= 1'b0;
    end else begin
      m_nx = m_st;
      if (sleep) m_nx = 0;
      else case (m_st)
        0: m_nx = 1;
        1: if (ref_tick && m_sc == S_TICKS-1) m_nx = 2;
        2: if (word_seen && line_active) m_nx = 3;
        default: if (!line_active || (rec_tick && !word_seen && m_tc == T_TICKS-1)) m_nx = 2;
      endcase
      if (m_st != 1) m_sc <= 0;
      else if (ref_tick) m_sc <= (m_sc == S_TICKS-1) ? 0 : m_sc + 1;
      if (m_st != 3 || word_seen) m_tc <= 0;
      else if (rec_tick) m_tc <= (m_tc == T_TICKS-1) ? 0 : m_tc + 1;
      m_str <= ((m_nx == 3) != (m_st == 3));
      m_st  <= m_nx;
    end
  end

  function automatic logic exp_valid(int st, logic act);
    return (st == 3) && act;
  endfunction

  task automatic chk(string t, string what, logic act, logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", t, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    chk(tag,  "lock_n",        lock_n,        ~exp_valid(m_st, line_active));
    chk("R9", "zero_data",     zero_data,     ~exp_valid(m_st, line_active));
    chk("R2", "drive_en",      drive_en,      ~sleep & out_en);
    chk("R5", "sel_recovered", sel_recovered, m_st == 3);
    chk("R8", "stretch_req",   stretch_req,   m_str);
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  task automatic idle_inputs();
    sleep = 0; out_en = 1; ref_tick = 0; rec_tick = 0; line_active = 1; word_seen = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  int unsigned seed;
  initial begin
    seed = 32'd1234;
    void'($urandom(seed));
    idle_inputs();
    sleep = 1;
    rst_n = 0;
    #(CLK_PERIOD * 2);
    @(negedge clk);
    // R3: reset state
    tag = "R3";
    chk("R3", "lock_n at reset", lock_n, 1'b1);
    chk("R3", "zero_data at reset", zero_data, 1'b1);
    chk("R1", "drive_en while sleep", drive_en, 1'b0);
    rst_n = 1;
    cyc();
    // R1: release sleep, settle begins
    sleep = 0;
    cyc();
    // R4: word strobe during settle is ignored; count ticks
    tag = "R4";
    for (int i = 0; i < S_TICKS; i++) begin
      ref_tick = 1; word_seen = (i == 3);
      cyc();
      ref_tick = 0; word_seen = 0;
      cyc();
      chk("R4", "no lock during settle", lock_n, 1'b1);
    end
    // R10: strobe with idle line in search is ignored
    tag = "R10";
    line_active = 0; word_seen = 1;
    cyc();
    line_active = 1; word_seen = 0;
    cyc();
    chk("R10", "lock_n after idle-line strobe", lock_n, 1'b1);
    // R5: lock
    tag = "R5";
    word_seen = 1;
    cyc();
    word_seen = 0;
    chk("R5", "lock_n after word", lock_n, 1'b0);
    chk("R8", "stretch on lock", stretch_req, 1'b1);
    cyc();
    chk("R8", "stretch single cycle", stretch_req, 1'b0);
    // R7: strobe one tick before expiry restarts the timeout
    tag = "R7";
    for (int i = 0; i < T_TICKS-1; i++) begin rec_tick = 1; cyc(); end
    rec_tick = 0; word_seen = 1; cyc(); word_seen = 0;
    for (int i = 0; i < T_TICKS-1; i++) begin rec_tick = 1; cyc(); end
    rec_tick = 0; cyc();
    chk("R7", "still locked after restart", lock_n, 1'b0);
    // R6: final tick expires the timeout
    tag = "R6";
    rec_tick = 1; cyc(); rec_tick = 0;
    chk("R6", "unlocked after timeout", lock_n, 1'b1);
    chk("R6", "reference clock after timeout", sel_recovered, 1'b0);
    chk("R8", "stretch on timeout", stretch_req, 1'b1);
    // R9: relock, then lose activity
    tag = "R9";
    word_seen = 1; cyc(); word_seen = 0;
    line_active = 0;
    #1;
    chk("R9", "lock_n on idle line", lock_n, 1'b1);
    cyc();
    line_active = 1;
    cyc();
    chk("R9", "search after idle line", sel_recovered, 1'b0);
    // R2: out_en low while locked
    tag = "R2";
    word_seen = 1; cyc(); word_seen = 0;
    out_en = 0; cyc();
    chk("R2", "drive_en low with out_en low", drive_en, 1'b0);
    out_en = 1;
    // R1: sleep while locked
    tag = "R1";
    sleep = 1; cyc(); sleep = 0;
    chk("R1", "lock_n after sleep", lock_n, 1'b1);
    // Random phase
    tag = "R5";
    for (int i = 0; i < 6000; i++) begin
      ref_tick    = ($urandom % 2) == 0;
      rec_tick    = ($urandom % 3) != 0;
      word_seen   = ($urandom % 60) == 0;
      line_active = ($urandom % 80) != 0;
      out_en      = ($urandom % 20) != 0;
      sleep       = ($urandom % 400) == 0;
      cyc();
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule